// File: doc/BRIEF.md
# Character LCD Command Sequencer

This block sits between a host and a character display controller that has an 8-bit parallel bus, a register-select line, a read/write line and an enable strobe. The host gives one request at a time as an opcode, a byte argument and a controller select. The block turns each request into bus cycles: an initialisation set, a character write, clear, home, cursor move, jump to the second line, or a one-step cursor shift left or right.

Before every write the block reads the status register until its busy bit is clear. After a shift, it reads the cursor address back from that register. If the address has run past the last column of the first line, the block issues one more command to correct it. A left shift that runs past that column parks the cursor on it; a right shift that runs past it sends the cursor home. Large panels carry two controllers on one data bus. A select input steers the strobe onto one of two enable lines.

Bus timing is set in clock cycles by parameters: register-select and read/write setup before the strobe, strobe width, and hold after it. This lets the strobe meet a display access time of about 450 ns at any clock rate. The defaults give 113 cycles, or 452 ns, at 250 MHz.

Top module: `lcd_cmd_seq`

## Requirements
- R1: Every bus cycle drives register-select, read/write and (for writes) the data bus for exactly SETUP_CYC cycles before the enable rises. The enable stays high for exactly EN_CYC cycles. The same values are held for exactly HOLD_CYC cycles after the enable falls.
- R2: A status read has register-select 0 and read/write 1, and keeps `lcd_d_oe` low for the whole cycle. Bit 7 of the value read is the busy flag and bits 6:0 are the cursor address.
- R3: Each write is preceded by a status read on the same controller that returned bit 7 = 0. While bit 7 reads 1, the status read is repeated.
- R4: Opcode 0 (init) writes the commands 0x38, 0x38, 0x06 and 0x0E, in that order.
- R5: Opcode 1 (put character) writes `arg` with register-select 1. Every command write has register-select 0.
- R6: Opcode 2 (clear) writes 0x01, opcode 3 (home) writes 0x02 and opcode 5 (second line) writes 0xC0.
- R7: Opcode 4 (goto) writes 0x80 OR `arg[6:0]`.
- R8: Opcode 6 (shift left) writes 0x10 and then reads the cursor address. If the address is above 0x27 it also writes 0xA7; otherwise it writes nothing more.
- R9: Opcode 7 (shift right) writes 0x14 and then reads the cursor address. If the address is above 0x27 it also writes 0x02; otherwise it writes nothing more.
- R10: With `sel` = 0 only `lcd_e1` strobes, and with `sel` = 1 only `lcd_e2` strobes. The two are never high together.
- R11: `ready` is high when idle. It goes low in the cycle after a request is accepted and stays low until the hold time of the last write ends. A request raised while `ready` is low is ignored.
- R12: During and right after reset, `ready` is 1, both enables are 0 and `lcd_d_oe` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req | input | 1 | Request strobe, taken when `ready` is high |
| op | input | 3 | Opcode of the request |
| arg | input | 8 | Character or cursor address |
| sel | input | 1 | Controller select: 0 first, 1 second |
| ready | output | 1 | Idle and able to take a request |
| lcd_rs | output | 1 | Register select: 0 command/status, 1 data |
| lcd_rw | output | 1 | 1 read, 0 write |
| lcd_e1 | output | 1 | Enable strobe of the first controller |
| lcd_e2 | output | 1 | Enable strobe of the second controller |
| lcd_d_out | output | 8 | Data driven onto the display bus |
| lcd_d_oe | output | 1 | Output enable of the data bus driver |
| lcd_d_in | input | 8 | Data read from the display bus |

## Verification
A sequencer that loses its place in a multi-step request shows up at the very next write strobe: the byte, register-select or enable line differs from the expected one, or a write comes with no clear status read ahead of it. A wrong wrap decision shows up within one bus cycle after the shift command, either as an extra or missing correction write, or as `ready` rising too early. A miscounted phase counter shows up on the first strobe as a wrong setup, width or hold length.

// File: rtl/lcd_seq_pkg.sv
package lcd_seq_pkg;

  typedef enum logic [2:0] {
    OP_INIT  = 3'd0,
    OP_PUTC  = 3'd1,
    OP_CLEAR = 3'd2,
    OP_HOME  = 3'd3,
    OP_GOTO  = 3'd4,
    OP_LINE2 = 3'd5,
    OP_LEFT  = 3'd6,
    OP_RIGHT = 3'd7
  } lcd_op_e;

  localparam logic [6:0] LAST_COL = 7'h27;

  // number of plain writes a request makes before any wrap correction
  function automatic logic [2:0] write_count(lcd_op_e op);
    return (op == OP_INIT) ? 3'd4 : 3'd1;
  endfunction

  // byte written at a given step of a request
  function automatic logic [7:0] step_byte(lcd_op_e op, logic [1:0] step, logic [7:0] arg);
    logic [7:0] b;
    case (op)
      OP_INIT: begin
        case (step)
          2'd0, 2'd1: b = 8'h38;
          2'd2:       b = 8'h06;
          default:    b = 8'h0E;
        endcase
      end
      OP_PUTC:  b = arg;
      OP_CLEAR: b = 8'h01;
      OP_HOME:  b = 8'h02;
      OP_GOTO:  b = {1'b1, arg[6:0]};
      OP_LINE2: b = 8'hC0;
      OP_LEFT:  b = 8'h10;
      default:  b = 8'h14;
    endcase
    return b;
  endfunction

  function automatic logic is_data(lcd_op_e op);
    return op == OP_PUTC;
  endfunction

  function automatic logic is_shift(lcd_op_e op);
    return (op == OP_LEFT) || (op == OP_RIGHT);
  endfunction

  function automatic logic past_last_col(logic [6:0] addr);
    return addr > LAST_COL;
  endfunction

  // correction command after a shift that ran past the last column
  function automatic logic [7:0] wrap_byte(lcd_op_e op);
    return (op == OP_LEFT) ? {1'b1, LAST_COL} : 8'h02;
  endfunction

endpackage

// File: rtl/lcd_bus_engine.sv
module lcd_bus_engine #(
  parameter int SETUP_CYC = 12,
  parameter int EN_CYC    = 113,
  parameter int HOLD_CYC  = 3
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       go,
  input  logic       is_read,
  input  logic       rs_in,
  input  logic       sel_in,
  input  logic [7:0] wdata,
  output logic       done,
  output logic [7:0] rdata,
  output logic       bus_rs,
  output logic       bus_rw,
  output logic       bus_e1,
  output logic       bus_e2,
  output logic [7:0] bus_dout,
  output logic       bus_doe,
  input  logic [7:0] bus_din
);

  localparam int MAX_SE = (SETUP_CYC > EN_CYC) ? SETUP_CYC : EN_CYC;
  localparam int MAXC   = (MAX_SE > HOLD_CYC) ? MAX_SE : HOLD_CYC;
  localparam int CW     = $clog2(MAXC + 1);
  localparam logic [CW-1:0] SETUP_LAST = CW'(SETUP_CYC - 1);
  localparam logic [CW-1:0] EN_LAST    = CW'(EN_CYC - 1);
  localparam logic [CW-1:0] HOLD_LAST  = CW'(HOLD_CYC - 1);

  typedef enum logic [1:0] {PH_IDLE, PH_SETUP, PH_EN, PH_HOLD} phase_e;

  phase_e        ph_q;
  logic [CW-1:0] cnt_q;
  logic          rs_q, rw_q, sel_q;
  logic [7:0]    dout_q, rdata_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph_q    <= PH_IDLE;
      cnt_q   <= '0;
      rs_q    <= 1'b0;
      rw_q    <= 1'b1;
      sel_q   <= 1'b0;
      dout_q  <= 8'h00;
      rdata_q <= 8'h00;
    end else begin
      case (ph_q)
        PH_IDLE: if (go) begin
          rs_q   <= rs_in;
          rw_q   <= is_read;
          sel_q  <= sel_in;
          dout_q <= is_read ? 8'h00 : wdata;
          cnt_q  <= '0;
          ph_q   <= PH_SETUP;
        end
        PH_SETUP: if (cnt_q == SETUP_LAST) begin
          cnt_q <= '0;
          ph_q  <= PH_EN;
        end else cnt_q <= cnt_q + 1'b1;
        PH_EN: if (cnt_q == EN_LAST) begin
          cnt_q <= '0;
          ph_q  <= PH_HOLD;
          if (rw_q) rdata_q <= bus_din;
        end else cnt_q <= cnt_q + 1'b1;
        default: if (cnt_q == HOLD_LAST) begin
          cnt_q <= '0;
          ph_q  <= PH_IDLE;
          rw_q  <= 1'b1;
          rs_q  <= 1'b0;
        end else cnt_q <= cnt_q + 1'b1;
      endcase
    end
  end

  assign done     = (ph_q == PH_HOLD) && (cnt_q == HOLD_LAST);
  assign rdata    = rdata_q;
  assign bus_rs   = rs_q;
  assign bus_rw   = rw_q;
  assign bus_e1   = (ph_q == PH_EN) && !sel_q;
  assign bus_e2   = (ph_q == PH_EN) && sel_q;
  assign bus_dout = dout_q;
  assign bus_doe  = (ph_q != PH_IDLE) && !rw_q;

  // strobe width measured at the pins
  logic        e_any;
  logic [15:0] e_run_q;
  assign e_any = bus_e1 || bus_e2;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     e_run_q <= '0;
    else if (e_any) e_run_q <= e_run_q + 16'd1;
    else            e_run_q <= '0;
  end

  assert_en_width_R1: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(e_any) |-> (e_run_q == 16'(EN_CYC)));

  assert_ctrl_stable_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (ph_q != PH_IDLE && $past(ph_q) != PH_IDLE) |->
      ($stable(bus_rs) && $stable(bus_rw) && $stable(bus_dout) && $stable(sel_q)));

endmodule

// File: rtl/lcd_seq_ctrl.sv
module lcd_seq_ctrl
  import lcd_seq_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       req,
  input  lcd_op_e    op,
  input  logic [7:0] arg,
  input  logic       sel,
  output logic       ready,
  output logic       eng_go,
  output logic       eng_read,
  output logic       eng_rs,
  output logic       eng_sel,
  output logic [7:0] eng_wdata,
  input  logic       eng_done,
  input  logic [7:0] eng_rdata
);

  typedef enum logic [2:0] {S_IDLE, S_POLL_GO, S_POLL_WT, S_WR_GO, S_WR_WT} state_e;

  state_e     st_q;
  lcd_op_e    op_q;
  logic [7:0] arg_q, wdata_q;
  logic       sel_q, rs_q, check_q, fix_q;
  logic [1:0] step_q;
  logic       more_steps;

  assign more_steps = ({1'b0, step_q} + 3'd1) < write_count(op_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q    <= S_IDLE;
      op_q    <= OP_INIT;
      arg_q   <= 8'h00;
      wdata_q <= 8'h00;
      sel_q   <= 1'b0;
      rs_q    <= 1'b0;
      check_q <= 1'b0;
      fix_q   <= 1'b0;
      step_q  <= 2'd0;
    end else begin
      case (st_q)
        S_IDLE: if (req) begin
          op_q    <= op;
          arg_q   <= arg;
          sel_q   <= sel;
          step_q  <= 2'd0;
          check_q <= 1'b0;
          fix_q   <= 1'b0;
          st_q    <= S_POLL_GO;
        end
        S_POLL_GO: st_q <= S_POLL_WT;
        S_POLL_WT: if (eng_done) begin
          if (eng_rdata[7]) begin
            st_q <= S_POLL_GO;
          end else if (check_q) begin
            check_q <= 1'b0;
            if (past_last_col(eng_rdata[6:0])) begin
              wdata_q <= wrap_byte(op_q);
              rs_q    <= 1'b0;
              st_q    <= S_WR_GO;
            end else begin
              st_q <= S_IDLE;
            end
          end else begin
            wdata_q <= step_byte(op_q, step_q, arg_q);
            rs_q    <= is_data(op_q);
            st_q    <= S_WR_GO;
          end
        end
        S_WR_GO: st_q <= S_WR_WT;
        default: if (eng_done) begin
          if (!fix_q && more_steps) begin
            step_q <= step_q + 2'd1;
            st_q   <= S_POLL_GO;
          end else if (!fix_q && is_shift(op_q)) begin
            check_q <= 1'b1;
            fix_q   <= 1'b1;
            st_q    <= S_POLL_GO;
          end else begin
            st_q <= S_IDLE;
          end
        end
      endcase
    end
  end

  assign ready     = (st_q == S_IDLE);
  assign eng_go    = (st_q == S_POLL_GO) || (st_q == S_WR_GO);
  assign eng_read  = (st_q == S_POLL_GO);
  assign eng_rs    = eng_read ? 1'b0 : rs_q;
  assign eng_sel   = sel_q;
  assign eng_wdata = wdata_q;

  assert_accept_drops_ready_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (req && ready) |=> !ready);

endmodule

// File: rtl/lcd_cmd_seq.sv
module lcd_cmd_seq
  import lcd_seq_pkg::*;
#(
  parameter int SETUP_CYC = 12,
  parameter int EN_CYC    = 113,
  parameter int HOLD_CYC  = 3
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       req,
  input  logic [2:0] op,
  input  logic [7:0] arg,
  input  logic       sel,
  output logic       ready,
  output logic       lcd_rs,
  output logic       lcd_rw,
  output logic       lcd_e1,
  output logic       lcd_e2,
  output logic [7:0] lcd_d_out,
  output logic       lcd_d_oe,
  input  logic [7:0] lcd_d_in
);

  logic       eng_go, eng_read, eng_rs, eng_sel, eng_done;
  logic [7:0] eng_wdata, eng_rdata;

  lcd_seq_ctrl u_ctrl (
    .clk       (clk),
    .rst_n     (rst_n),
    .req       (req),
    .op        (lcd_op_e'(op)),
    .arg       (arg),
    .sel       (sel),
    .ready     (ready),
    .eng_go    (eng_go),
    .eng_read  (eng_read),
    .eng_rs    (eng_rs),
    .eng_sel   (eng_sel),
    .eng_wdata (eng_wdata),
    .eng_done  (eng_done),
    .eng_rdata (eng_rdata)
  );

  lcd_bus_engine #(
    .SETUP_CYC (SETUP_CYC),
    .EN_CYC    (EN_CYC),
    .HOLD_CYC  (HOLD_CYC)
  ) u_bus (
    .clk      (clk),
    .rst_n    (rst_n),
    .go       (eng_go),
    .is_read  (eng_read),
    .rs_in    (eng_rs),
    .sel_in   (eng_sel),
    .wdata    (eng_wdata),
    .done     (eng_done),
    .rdata    (eng_rdata),
    .bus_rs   (lcd_rs),
    .bus_rw   (lcd_rw),
    .bus_e1   (lcd_e1),
    .bus_e2   (lcd_e2),
    .bus_dout (lcd_d_out),
    .bus_doe  (lcd_d_oe),
    .bus_din  (lcd_d_in)
  );

  // last completed status read: clear flag and the controller it came from
  logic strobe_any, poll_clear_q, poll_sel_q;
  assign strobe_any = lcd_e1 || lcd_e2;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      poll_clear_q <= 1'b0;
      poll_sel_q   <= 1'b0;
    end else if (eng_done && lcd_rw) begin
      poll_clear_q <= !eng_rdata[7];
      poll_sel_q   <= eng_sel;
    end else if (eng_done) begin
      poll_clear_q <= 1'b0;
    end
  end

  assert_clear_before_write_R3: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(strobe_any) && !lcd_rw) |-> (poll_clear_q && (poll_sel_q == lcd_e2)));

  assert_idle_no_strobe_R11: assert property (@(posedge clk) disable iff (!rst_n)
    strobe_any |-> !ready);

  assert_read_no_drive_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (strobe_any && lcd_rw) |-> (!lcd_d_oe && !lcd_rs));

endmodule

// File: tb/lcd_cmd_seq_test.sv
module lcd_cmd_seq_test;

  localparam int TB_SETUP = 12;
  localparam int TB_EN    = 113;
  localparam int TB_HOLD  = 3;
  localparam int BUSY_READS = 2;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       req = 1'b0;
  logic [2:0] op = 3'd0;
  logic [7:0] arg = 8'h00;
  logic       sel = 1'b0;
  logic       ready, lcd_rs, lcd_rw, lcd_e1, lcd_e2, lcd_d_oe;
  logic [7:0] lcd_d_out, lcd_d_in;

  always #2 clk = ~clk;

  lcd_cmd_seq #(.SETUP_CYC(TB_SETUP), .EN_CYC(TB_EN), .HOLD_CYC(TB_HOLD)) uut (
    .clk(clk), .rst_n(rst_n), .req(req), .op(op), .arg(arg), .sel(sel),
    .ready(ready), .lcd_rs(lcd_rs), .lcd_rw(lcd_rw), .lcd_e1(lcd_e1),
    .lcd_e2(lcd_e2), .lcd_d_out(lcd_d_out), .lcd_d_oe(lcd_d_oe), .lcd_d_in(lcd_d_in)
  );

  int total = 0;
  int bad = 0;
  bit fin = 0;

  task automatic chk(input bit ok, input string rq, input string what, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s: actual=%0h expected=%0h", rq, what, act, exp);
    end
  endtask

  // display model: two controllers, each with cursor and busy read count
  logic [6:0] addr_m [2];
  int         busy_m [2];
  bit         last_clear [2];

  always_comb lcd_d_in = {(busy_m[lcd_e2] != 0), addr_m[lcd_e2]};

  typedef struct packed {logic s; logic rs; logic [7:0] d;} wr_t;
  wr_t   exp_q[$];
  string tag_q[$];

  function automatic logic [6:0] next_addr(logic [6:0] a, logic rs, logic [7:0] d);
    if (rs) return a + 7'd1;
    if (d[7]) return d[6:0];
    if (d == 8'h01 || d == 8'h02) return 7'd0;
    if (d == 8'h10) return a - 7'd1;
    if (d == 8'h14) return a + 7'd1;
    return a;
  endfunction

  // monitor
  bit e_prev = 0, cur_sel = 0, in_post = 0;
  int e_len = 0, pre_cnt = 0, hold_cnt = 0;
  always @(negedge clk) begin
    if (rst_n && !fin) begin
      bit e_now;
      e_now = lcd_e1 | lcd_e2;
      if (lcd_e1 && lcd_e2) chk(0, "R10", "both enables high", 1, 0);
      if (e_now) begin
        e_len++;
        if (lcd_rw && (lcd_d_oe || lcd_rs)) chk(0, "R2", "status read drives bus", {lcd_rs, lcd_d_oe}, 0);
      end
      if (e_now && !e_prev) begin
        cur_sel = lcd_e2;
        if (!lcd_rw) chk(pre_cnt == TB_SETUP, "R1", "setup cycles", pre_cnt, TB_SETUP);
      end
      if (!e_now && e_prev) begin
        chk(e_len == TB_EN, "R1", "enable width", e_len, TB_EN);
        e_len = 0;
        if (lcd_rw) begin
          last_clear[cur_sel] = (busy_m[cur_sel] == 0);
          if (busy_m[cur_sel] > 0) busy_m[cur_sel]--;
        end else begin
          chk(last_clear[cur_sel], "R3", "write without clear status", 0, 1);
          if (exp_q.size() == 0) begin
            chk(0, "R11", "unexpected write", lcd_d_out, 0);
          end else begin
            wr_t e;
            string t;
            e = exp_q.pop_front();
            t = tag_q.pop_front();
            chk({cur_sel, lcd_rs, lcd_d_out} == e, t, "write sel/rs/byte",
                {cur_sel, lcd_rs, lcd_d_out}, e);
          end
          addr_m[cur_sel] = next_addr(addr_m[cur_sel], lcd_rs, lcd_d_out);
          busy_m[cur_sel] = BUSY_READS;
          last_clear[cur_sel] = 0;
          in_post = 1;
          hold_cnt = 0;
        end
      end
      if (lcd_d_oe && !e_now) begin
        if (in_post) hold_cnt++;
        else pre_cnt++;
      end
      if (!lcd_d_oe) begin
        if (in_post) chk(hold_cnt == TB_HOLD, "R1", "hold cycles", hold_cnt, TB_HOLD);
        in_post = 0;
        pre_cnt = 0;
      end
      e_prev = e_now;
    end
  end

  task automatic push(input logic s, input logic rs, input logic [7:0] d, input string t);
    exp_q.push_back({s, rs, d});
    tag_q.push_back(t);
  endtask

  // driver: predict writes, issue the request, wait for completion
  task automatic run_op(input int o, input logic [7:0] a, input logic s, input string t, input bit poke);
    logic [6:0] na;
    case (o)
      0: begin push(s,0,8'h38,t); push(s,0,8'h38,t); push(s,0,8'h06,t); push(s,0,8'h0E,t); end
      1: push(s, 1, a, t);
      2: push(s, 0, 8'h01, t);
      3: push(s, 0, 8'h02, t);
      4: push(s, 0, {1'b1, a[6:0]}, t);
      5: push(s, 0, 8'hC0, t);
      6: begin na = addr_m[s] - 7'd1; push(s,0,8'h10,t); if (na > 7'h27) push(s,0,8'hA7,t); end
      default: begin na = addr_m[s] + 7'd1; push(s,0,8'h14,t); if (na > 7'h27) push(s,0,8'h02,t); end
    endcase
    @(negedge clk);
    req = 1; op = 3'(o); arg = a; sel = s;
    @(negedge clk);
    req = 0;
    chk(!ready, "R11", "ready after accept", ready, 0);
    if (poke) begin
      repeat (20) @(negedge clk);
      req = 1; op = 3'd2; arg = 8'h00; sel = ~s;
      @(negedge clk);
      req = 0;
    end
    for (int n = 0; n < 40000 && !ready; n++) @(negedge clk);
    chk(ready, "R11", "ready at end", ready, 1);
    chk(exp_q.size() == 0, t, "pending writes", exp_q.size(), 0);
    repeat (5) @(negedge clk);
    chk(exp_q.size() == 0 && ready, "R11", "quiet after end", exp_q.size(), 0);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    if (!fin) begin
      fin = 1;
      total++; bad++;
      $display("FAIL watchdog: actual=1 expected=0");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < 2; i++) begin addr_m[i] = 7'd0; busy_m[i] = 0; last_clear[i] = 0; end
    repeat (3) @(negedge clk);
    chk(ready && !lcd_e1 && !lcd_e2 && !lcd_d_oe, "R12", "in reset", {ready,lcd_e1,lcd_e2,lcd_d_oe}, 4'b1000);
    rst_n = 1;
    @(negedge clk);
    chk(ready && !lcd_e1 && !lcd_e2 && !lcd_d_oe, "R12", "after reset", {ready,lcd_e1,lcd_e2,lcd_d_oe}, 4'b1000);
    busy_m[0] = 3;
    run_op(0, 8'h00, 0, "R4", 0);
    run_op(1, 8'h41, 0, "R5", 0);
    run_op(2, 8'h00, 0, "R6", 0);
    run_op(5, 8'h00, 0, "R6", 0);
    run_op(3, 8'h00, 0, "R6", 0);
    run_op(4, 8'hA7, 0, "R7", 0);
    run_op(7, 8'h00, 0, "R9", 0);
    chk(addr_m[0] == 7'd0, "R9", "right wrap goes home", addr_m[0], 0);
    run_op(4, 8'h10, 0, "R7", 0);
    run_op(7, 8'h00, 0, "R9", 0);
    run_op(4, 8'h26, 0, "R7", 0);
    run_op(7, 8'h00, 0, "R9", 0);
    chk(addr_m[0] == 7'h27, "R9", "right at boundary kept", addr_m[0], 7'h27);
    run_op(4, 8'h00, 0, "R7", 0);
    run_op(6, 8'h00, 0, "R8", 0);
    chk(addr_m[0] == 7'h27, "R8", "left wrap parks", addr_m[0], 7'h27);
    run_op(6, 8'h00, 0, "R8", 0);
    chk(addr_m[0] == 7'h26, "R8", "left no wrap", addr_m[0], 7'h26);
    run_op(0, 8'h00, 1, "R10", 0);
    run_op(1, 8'h7A, 1, "R10", 1);
    chk(addr_m[1] == 7'd1 && addr_m[0] == 7'h26, "R11", "ignored request left cursors", addr_m[1], 1);
    fin = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule